// File: doc/BRIEF.md
# Reset Cause Controller

This block collects every internal reason for resetting a small microcontroller, sequences the exit from reset, and keeps a five-flag status word that firmware reads after start-up to learn why the part restarted. It takes qualification signals from the instruction decoder and the bus fetch logic, a stop-permission option bit, a trip input from the supply monitor, a watchdog request and an active-low power-on input.

Any internal cause pulls the reset pin low through an open-drain driver for one phase. The internal reset is then held for a second phase before the CPU is released. A power-on instead runs a long oscillator stabilisation phase and then two short phases. During that whole sequence the pin is never driven, so the board can use it as a general-purpose input. Causes are only taken while the CPU runs. Those that arrive together in one cycle are all recorded.

Status bit map: bit 0 watchdog, bit 1 illegal opcode, bit 2 illegal address, bit 3 low voltage, bit 4 power-on.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While running, a high `ill_op` sets status bit 1, clears the other flags and enters reset on the next clock edge.
- R2: A STOP execution (`stop_exec`) counts as an illegal opcode (status bit 1, reset) only when `stop_en` is 0. When `stop_en` is 1 it has no effect.
- R3: An unmapped access with `opcode_fetch` high sets status bit 2 and enters reset.
- R4: An unmapped access with `opcode_fetch` low causes no reset and leaves the status unchanged.
- R5: A high `lvd_trip` while running sets status bit 3 and enters reset.
- R6: A high `cop_req` while running sets status bit 0 and enters reset.
- R7: After an internal cause, `pin_drv_low` is high for exactly PHASE_CYC (32) cycles and `sys_rst` stays high for a further PHASE_CYC cycles.
- R8: While `por_n` is low, status reads 5'b10000, `sys_rst` is high and `pin_drv_low` is low. After `por_n` rises, `sys_rst` stays high for STAB_CYC+2*PHASE_CYC (4160) clock edges, and `pin_drv_low` stays low throughout.
- R9: A new cause writes exactly the set of causes present in that cycle, which clears every other flag, the power-on flag included.
- R10: A one-cycle `stat_rd` while running clears all flags. If a cause arrives in the same cycle, the cause's flags are stored instead.
- R11: Cause inputs are ignored while `sys_rst` is high: the status and the phase lengths stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ill_op | input | 1 | Decoder flags an undefined instruction |
| stop_exec | input | 1 | STOP instruction is executing |
| stop_en | input | 1 | Option bit permitting STOP |
| fetch_unmapped | input | 1 | Current bus access hits an unmapped address |
| opcode_fetch | input | 1 | Current bus access is an opcode fetch |
| lvd_trip | input | 1 | Supply monitor trip |
| cop_req | input | 1 | Watchdog timeout request |
| stat_rd | input | 1 | Status register read strobe |
| pin_drv_low | output | 1 | Enable for the open-drain pull-down on the reset pin |
| sys_rst | output | 1 | Internal system reset |
| status | output | 5 | Reset cause flags |

## Verification
The assertions check on every cycle that each qualified cause lands in its flag one edge later. They also check that a data-side unmapped access never starts a reset, that the pin is only driven inside reset for exactly one phase, and that the status is frozen while reset is active. The power-on phase lengths, the undriven pin during power-on recovery, and read-clear against a simultaneous cause can only be shown by the bench's scenarios. The same holds for the full sweep of all 128 combinations of cause inputs.

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl #(
  parameter int STAB_CYC  = 4096,
  parameter int PHASE_CYC = 32
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ill_op,
  input  logic       stop_exec,
  input  logic       stop_en,
  input  logic       fetch_unmapped,
  input  logic       opcode_fetch,
  input  logic       lvd_trip,
  input  logic       cop_req,
  input  logic       stat_rd,
  output logic       pin_drv_low,
  output logic       sys_rst,
  output logic [4:0] status
);
  localparam int MAXC = (STAB_CYC > PHASE_CYC) ? STAB_CYC : PHASE_CYC;
  localparam int CW   = $clog2(MAXC);

  typedef enum logic [2:0] {ST_STAB, ST_PSYNC, ST_PIN, ST_HOLD, ST_RUN} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [4:0]   cause;
  logic         run, hit, stab_done, phase_done;

  assign run        = (st == ST_RUN);
  assign cause      = {1'b0, lvd_trip, fetch_unmapped & opcode_fetch,
                       ill_op | (stop_exec & ~stop_en), cop_req};
  assign hit        = run & (|cause);
  assign stab_done  = (cnt == CW'(STAB_CYC - 1));
  assign phase_done = (cnt == CW'(PHASE_CYC - 1));

  assign sys_rst     = ~run;
  assign pin_drv_low = (st == ST_PIN);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st     <= ST_STAB;
      cnt    <= '0;
      status <= 5'b10000;
    end else begin
      cnt <= cnt + CW'(1);
      case (st)
        ST_STAB:  if (stab_done)  begin st <= ST_PSYNC; cnt <= '0; end
        ST_PSYNC: if (phase_done) begin st <= ST_HOLD;  cnt <= '0; end
        ST_PIN:   if (phase_done) begin st <= ST_HOLD;  cnt <= '0; end
        ST_HOLD:  if (phase_done) begin st <= ST_RUN;   cnt <= '0; end
        ST_RUN: begin
          cnt <= '0;
          if (hit) begin
            st     <= ST_PIN;
            status <= cause;
          end else if (stat_rd) begin
            status <= '0;
          end
        end
        default: begin st <= ST_STAB; cnt <= '0; end
      endcase
    end
  end
endmodule

module rst_cause_chk #(
  parameter int PHASE_CYC = 32
) (
  input logic       clk,
  input logic       por_n,
  input logic       ill_op,
  input logic       stop_exec,
  input logic       stop_en,
  input logic       fetch_unmapped,
  input logic       opcode_fetch,
  input logic       lvd_trip,
  input logic       cop_req,
  input logic       stat_rd,
  input logic       pin_drv_low,
  input logic       sys_rst,
  input logic [4:0] status
);
  localparam int PW = $clog2(PHASE_CYC + 1) + 1;
  logic [PW-1:0] pcnt;
  logic          any_cause;

  assign any_cause = ill_op | (stop_exec & ~stop_en) | (fetch_unmapped & opcode_fetch)
                   | lvd_trip | cop_req;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           pcnt <= '0;
    else if (pin_drv_low) pcnt <= pcnt + PW'(1);
    else                  pcnt <= '0;
  end

  AST_ILOP_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && ill_op) |=> (status[1] && pin_drv_low)); // R1
  AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && stop_exec && !stop_en) |=> status[1]); // R2
  AST_ILAD_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && fetch_unmapped && opcode_fetch) |=> status[2]); // R3
  AST_DATA_NO_RST: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && !any_cause) |=> !sys_rst); // R4
  AST_LVI_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && lvd_trip) |=> status[3]); // R5
  AST_COP_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && cop_req) |=> status[0]); // R6
  AST_PIN_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
    pin_drv_low |-> sys_rst); // R7
  AST_PIN_NO_OVER: assert property (@(posedge clk) disable iff (!por_n)
    pin_drv_low |-> (pcnt < PW'(PHASE_CYC))); // R7
  AST_PIN_LEN: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pin_drv_low) |-> (pcnt == PW'(PHASE_CYC))); // R7
  AST_POR_CLR: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pin_drv_low) |-> !status[4]); // R9
  AST_READ_CLR: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && stat_rd && !any_cause) |=> (status == 5'b0)); // R10
  AST_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> $stable(status)); // R11
endmodule

bind rst_cause_ctrl rst_cause_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
  .clk(clk), .por_n(por_n), .ill_op(ill_op), .stop_exec(stop_exec),
  .stop_en(stop_en), .fetch_unmapped(fetch_unmapped), .opcode_fetch(opcode_fetch),
  .lvd_trip(lvd_trip), .cop_req(cop_req), .stat_rd(stat_rd),
  .pin_drv_low(pin_drv_low), .sys_rst(sys_rst), .status(status)
);

// File: tb/rst_cause_ctrl_tb.sv
module rst_cause_ctrl_tb;
  logic clk = 1'b0;
  logic por_n, ill_op, stop_exec, stop_en, fetch_unmapped, opcode_fetch;
  logic lvd_trip, cop_req, stat_rd;
  logic pin_drv_low, sys_rst;
  logic [4:0] status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [4:0] exp_stat;

  always #10 clk = ~clk;

  rst_cause_ctrl u_dut (
    .clk(clk), .por_n(por_n), .ill_op(ill_op), .stop_exec(stop_exec),
    .stop_en(stop_en), .fetch_unmapped(fetch_unmapped), .opcode_fetch(opcode_fetch),
    .lvd_trip(lvd_trip), .cop_req(cop_req), .stat_rd(stat_rd),
    .pin_drv_low(pin_drv_low), .sys_rst(sys_rst), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr_in();
    ill_op = 0; stop_exec = 0; stop_en = 0; fetch_unmapped = 0;
    opcode_fetch = 0; lvd_trip = 0; cop_req = 0; stat_rd = 0;
  endtask

  task automatic count_phases(input string tag, input bool_lvd_mid);
    int n = 0;
    int m = 0;
    while (pin_drv_low) begin
      n++;
      if (bool_lvd_mid && n == 5) lvd_trip = 1;
      @(negedge clk);
      lvd_trip = 0;
    end
    while (sys_rst) begin
      m++;
      if (bool_lvd_mid && m == 3) cop_req = 1;
      @(negedge clk);
      cop_req = 0;
    end
    chk(n == 32, tag, n, 32);
    chk(m == 32, tag, m, 32);
  endtask

  task automatic apply(input logic [6:0] v);
    logic [4:0] e;
    bit hit;
    {cop_req, lvd_trip, opcode_fetch, fetch_unmapped, stop_en, stop_exec, ill_op} = v;
    e = {1'b0, v[5], v[4] & v[3], v[0] | (v[1] & ~v[2]), v[6]};
    hit = |e;
    @(posedge clk);
    @(negedge clk);
    clr_in();
    if (hit) begin
      chk(sys_rst == 1'b1, "R9_enter", sys_rst, 1);
      chk(status[1] == e[1], (v[1] && !v[0]) ? "R2_stop" : "R1_ilop", status[1], e[1]);
      chk(status[2] == e[2], "R3_ilad", status[2], e[2]);
      chk(status[3] == e[3], "R5_lvi", status[3], e[3]);
      chk(status[0] == e[0], "R6_cop", status[0], e[0]);
      chk(status == e, "R9_set", status, e);
      count_phases("R7_len", 1'b0);
      exp_stat = e;
    end else begin
      chk(sys_rst == 1'b0, (v[3] && !v[4]) ? "R4_data" : "R2_nostop", sys_rst, 0);
      chk(status == exp_stat, "R4_keep", status, exp_stat);
    end
  endtask

  initial begin
    int n;
    bit pin_seen;
    clr_in();
    por_n = 0;
    exp_stat = 5'b10000;
    repeat (3) @(negedge clk);
    chk(sys_rst == 1'b1, "R8_rst", sys_rst, 1);
    chk(pin_drv_low == 1'b0, "R8_pin", pin_drv_low, 0);
    chk(status == 5'b10000, "R8_stat", status, 5'b10000);

    por_n = 1;
    n = 0;
    pin_seen = 0;
    do begin
      @(negedge clk);
      n++;
      if (pin_drv_low) pin_seen = 1;
      if (n == 100) ill_op = 1;
      if (n == 101) ill_op = 0;
    end while (sys_rst && n < 10000);
    chk(n == 4160, "R8_len", n, 4160);
    chk(pin_seen == 0, "R8_gpio", pin_seen, 0);
    chk(status == 5'b10000, "R11_por", status, 5'b10000);

    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    chk(status == 5'b0, "R10_clr", status, 0);
    exp_stat = 5'b0;

    for (int v = 0; v < 128; v++) apply(7'(v));

    cop_req = 1;
    @(negedge clk);
    cop_req = 0;
    chk(status == 5'b00001, "R11_pre", status, 1);
    count_phases("R11_len", 1'b1);
    chk(status == 5'b00001, "R11_keep", status, 1);

    stat_rd = 1; lvd_trip = 1;
    @(negedge clk);
    clr_in();
    chk(status == 5'b01000, "R10_race", status, 5'b01000);
    count_phases("R7_race", 1'b0);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    chk(status == 5'b0, "R10_after", status, 0);
    chk(sys_rst == 1'b0, "R10_run", sys_rst, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule